// File: doc/BRIEF.md
# Modulo-N Synchronous Binary Counter

This block is a synchronous binary up-counter with a parallel load, a count enable and a carry output, wrapped so that it counts modulo N. When the count reaches the terminal value N-1 and counting is enabled, the next clock edge reloads zero through the same synchronous path that the parallel load uses. Every state therefore lasts a full clock period, and no count value appears only briefly as it would with an asynchronous clear on N. The reset is asynchronous, and it only initialises the counter. It plays no part in wrapping.

Each cycle is sorted into one of four named actions: ACT_LOAD (load asserted, which takes priority), ACT_INC (counting below the terminal value), ACT_WRAP (counting at the terminal value, which reloads zero) and ACT_HOLD (neither load nor count). The transitions are: any state to the loaded value on ACT_LOAD; state k to k+1 on ACT_INC; N-1 to 0 on ACT_WRAP; and k to k on ACT_HOLD. The width and modulus are parameters. When N is 7, the terminal-count decode is reduced to the AND of bits 2 and 1, because no state above 6 can be reached. The carry output is combinational, so it can feed the count enable of the next, more significant stage.

Top module: `modn_counter`

## Requirements
- R1: While rst_n is 0, cnt_q becomes 0 at once, without waiting for a clock edge, and carry_out is 0 whenever count_en is 0.
- R2: When load_en is 1, the next rising edge stores load_val into cnt_q, whatever the value of count_en.
- R3: When load_en is 0 and count_en is 0, cnt_q keeps its value across the edge.
- R4: When load_en is 0, count_en is 1 and cnt_q is below N-1, cnt_q increases by one on the edge.
- R5: When load_en is 0, count_en is 1 and cnt_q equals N-1, cnt_q becomes 0 on the edge through a synchronous reload. The value N-1 stays visible for a full clock period.
- R6: carry_out is 1 exactly when count_en is 1 and cnt_q equals N-1. This is the all-ones value when N is 2^WIDTH. carry_out does not depend on load_en.
- R7: Provided every loaded value is below N, cnt_q never holds a value outside 0..N-1 after reset.
- R8: From 0, with count_en held at 1, cnt_q runs through 0,1,...,N-1 and returns to 0 after exactly N edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the count |
| load_en | input | 1 | Parallel load request; has priority over counting |
| count_en | input | 1 | Count enable |
| load_val | input | WIDTH | Value loaded when load_en is 1 |
| cnt_q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal count AND count_en, for cascading |

## Verification
The assertions assume that every value presented on load_val during a load is below N. A load of a larger value would place the counter outside its cycle, where the terminal decode never fires. For N = 7 this matters twice over, because the reduced decode would misread states above 6. The bench only loads values from 0 to N-1, and it sweeps each of these with count_en both low and high, so the range assertion and the bench's own per-cycle range check rest on that premise.

// File: rtl/modn_pkg.sv
package modn_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_WRAP = 2'd2,
        ACT_LOAD = 2'd3
    } act_e;
endpackage

// File: rtl/modn_tc_decode.sv
module modn_tc_decode #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 7
) (
    input  logic [WIDTH-1:0] q,
    output logic             tc
);
    generate
        if (MODULUS == 7 && WIDTH >= 3) begin : g_reduced
            // States 7 and above cannot be reached, so 6 is the only state with bits 2 and 1 both set
            logic unused_q;
            assign unused_q = ^q;
            assign tc = q[2] & q[1];
        end else begin : g_full
            localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);
            assign tc = (q == TERM);
        end
    endgenerate
endmodule

// File: rtl/modn_action_sel.sv
module modn_action_sel
    import modn_pkg::*;
(
    input  logic load_en,
    input  logic count_en,
    input  logic tc,
    output act_e act
);
    always_comb begin
        act = ACT_HOLD;
        unique casez ({load_en, count_en, tc})
            3'b1??:  act = ACT_LOAD;
            3'b010:  act = ACT_INC;
            3'b011:  act = ACT_WRAP;
            3'b00?:  act = ACT_HOLD;
            default: act = ACT_HOLD;
        endcase
    end
endmodule

// File: rtl/modn_next_mux.sv
module modn_next_mux
    import modn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  act_e             act,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] next_q
);
    always_comb begin
        next_q = q;
        unique case (act)
            ACT_LOAD: next_q = load_val;
            ACT_WRAP: next_q = '0;
            ACT_INC:  next_q = q + WIDTH'(1);
            ACT_HOLD: next_q = q;
            default:  next_q = q;
        endcase
    end
endmodule

// File: rtl/modn_counter.sv
module modn_counter
    import modn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             count_en,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] cnt_q,
    output logic             carry_out
);
    logic             tc;
    act_e             act;
    logic [WIDTH-1:0] next_q;

    modn_tc_decode #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_tc (
        .q  (cnt_q),
        .tc (tc)
    );

    modn_action_sel u_act (
        .load_en  (load_en),
        .count_en (count_en),
        .tc       (tc),
        .act      (act)
    );

    modn_next_mux #(.WIDTH(WIDTH)) u_next (
        .act      (act),
        .q        (cnt_q),
        .load_val (load_val),
        .next_q   (next_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= next_q;
    end

    assign carry_out = count_en & tc;
endmodule

// File: rtl/modn_counter_chk.sv
module modn_counter_chk #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic             count_en,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] cnt_q,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

    AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) load_en |-> load_val <= TERM); // R7
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= TERM); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) load_en |=> cnt_q == $past(load_val)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!load_en && !count_en) |=> $stable(cnt_q)); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n) (!load_en && count_en && cnt_q != TERM) |=> cnt_q == $past(cnt_q) + WIDTH'(1)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!load_en && count_en && cnt_q == TERM) |=> cnt_q == '0); // R5
    AST_CARRY_TERM: assert property (@(posedge clk) disable iff (!rst_n) carry_out == (count_en && cnt_q == TERM)); // R6
endmodule

bind modn_counter modn_counter_chk #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .count_en  (count_en),
    .load_val  (load_val),
    .cnt_q     (cnt_q),
    .carry_out (carry_out)
);

// File: tb/modn_counter_bench.sv
`timescale 1ns/1ps
module modn_counter_bench;
    localparam int W = 4;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic         count_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] cnt_q;
    logic         carry_out;

    int checks = 0;
    int failures = 0;
    int exp_q = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    modn_counter #(.WIDTH(W), .MODULUS(N)) u_modn_counter (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .count_en(count_en),
        .load_val(load_val), .cnt_q(cnt_q), .carry_out(carry_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and advances the model
    task automatic step(input bit ld, input bit cn, input int d, input string req);
        chk(req, int'(cnt_q), exp_q);
        chk("R7", int'(cnt_q < N), 1);
        load_en = ld; count_en = cn; load_val = W'(d);
        #1;
        chk("R6", int'(carry_out), int'(cn && exp_q == N - 1));
        @(posedge clk);
        if (ld)      exp_q = d;
        else if (cn) exp_q = (exp_q == N - 1) ? 0 : exp_q + 1;
        @(negedge clk);
    endtask

    initial begin
        #1;
        chk("R1", int'(cnt_q), 0);
        chk("R1", int'(carry_out), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R8: a full lap from zero returns to zero after N edges
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, 0, "R4");
        chk("R8", int'(cnt_q), 0);
        // R4 R5: several laps with wrapping
        for (int i = 0; i < 3 * N + 2; i++) step(1'b0, 1'b1, 0, "R5");
        // R3: hold in every state
        for (int v = 0; v < N; v++) begin
            step(1'b1, 1'b0, v, "R2");
            for (int h = 0; h < 3; h++) step(1'b0, 1'b0, 9, "R3");
        end
        // R2: load wins over count for every in-range value
        for (int v = 0; v < N; v++) begin
            step(1'b1, 1'b1, v, "R2");
            step(1'b0, 1'b1, 0, "R4");
            step(1'b1, 1'b1, N - 1 - v, "R2");
        end
        // R5: the terminal value lasts a full period while held, then wraps
        step(1'b1, 1'b0, N - 1, "R2");
        step(1'b0, 1'b0, 0, "R3");
        step(1'b0, 1'b1, 0, "R5");
        chk("R5", int'(cnt_q), 0);
        // R1: asynchronous reset mid-cycle
        step(1'b1, 1'b0, 5, "R2");
        step(1'b0, 1'b0, 0, "R3");
        rst_n = 1'b0;
        #1;
        chk("R1", int'(cnt_q), 0);
        exp_q = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0, "R4");
        chk("R4", int'(cnt_q), exp_q);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule